// File: doc/BRIEF.md
# Pilot-Framed Subcarrier Mapper

This block arranges a stream of spread, interleaved complex chips into frequency-domain bins ready for an inverse FFT. The output is built as frames. Each frame opens with one pilot symbol and then carries a programmable number of data symbols. Every symbol spans `cfg_nfft` bins. Only `cfg_nused` of those bins carry content, and they sit in the middle of the band. The remaining carriers are nulls, split equally between the low-index edge and the high-index edge.

In the pilot symbol, every used bin holds the same fixed pilot word, so the pilot power does not change with the configuration. In a data symbol, each used bin takes the next chip from the input stream. The block holds its input back whenever the current bin is a pilot bin or a null bin, and it emits those bins at one per cycle. Each output bin carries its index and markers for symbol start and frame start. The guard length in samples is passed to the stage downstream; a typical value is 16 at 20 MHz or 40 at 50 MHz sampling.

The configuration is captured during reset and again at each frame boundary. A change made in the middle of a frame therefore takes effect at the next frame.

Top module: `subcarrier_mapper`

## Requirements
- R1: While `rst` is high, `in_ready` is low. On the edge after any cycle with `rst` high, `o_valid`, `o_sym_start` and `o_frame_start` are low.
- R2: Symbols follow the order pilot symbol (index 0), then data symbols 1 to `cfg_nsym`, then back to a new pilot symbol. Bins within a symbol are emitted as 0 to `cfg_nfft`-1, and `o_bin` carries the index. `o_frame_start` is high only with bin 0 of the pilot symbol.
- R3: With lo = (`cfg_nfft`-`cfg_nused`)/2, bins below lo and bins at or above lo+`cfg_nused` are nulls. Both rails of a null bin are exactly zero, in every symbol.
- R4: In the pilot symbol, every used bin carries I = `PILOT_RE` (default 1448) and Q = 0, for any configuration.
- R5: In a data symbol, the used bins carry the accepted input chips in order of acceptance, with I and Q unchanged. A chip accepted at a clock edge appears on the outputs at that same edge.
- R6: `in_ready` is high exactly when the current bin is a used bin of a data symbol. Pilot bins and null bins are emitted one per cycle and consume no input.
- R7: When the current bin is a data bin and `in_valid` is low, no bin is emitted on that edge (`o_valid` low) and the position is held.
- R8: `o_sym_start` is high exactly with bin 0 of every symbol.
- R9: The configuration inputs are sampled only during reset and on the edge that emits the final bin of a frame. A change made mid-frame has no effect on the current frame.
- R10: With each frame-start bin, `o_guard` equals the guard length captured for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nfft | input | 9 | Bins per symbol (even, at most NFFT_MAX) |
| cfg_nused | input | 9 | Used bins per symbol (even, at most cfg_nfft) |
| cfg_nsym | input | 10 | Data symbols per frame (at least 1) |
| cfg_guard | input | 8 | Guard length in samples, passed downstream |
| in_valid | input | 1 | Input chip available |
| in_ready | output | 1 | Current bin accepts a chip |
| in_i | input | 12 | Chip in-phase part |
| in_q | input | 12 | Chip quadrature part |
| o_valid | output | 1 | Output bin valid |
| o_i | output | 12 | Bin in-phase value |
| o_q | output | 12 | Bin quadrature value |
| o_bin | output | 9 | Bin index within the symbol |
| o_sym_start | output | 1 | First bin of a symbol |
| o_frame_start | output | 1 | First bin of a frame |
| o_guard | output | 8 | Guard length of the current frame |

## Verification
The properties assume that the configuration is legal whenever it is captured: `cfg_nfft` is even and non-zero, `cfg_nused` is even and no larger than `cfg_nfft`, and `cfg_nsym` is at least 1. The stimulus drives only such settings. It covers a band without nulls, a small band with nulls, and the 64/48 and 256/192 layouts. One settings change is made while a frame is in progress. The input stream is gapped in three duty patterns, so that stalls land on many different data bins. The null-zero property compares each bin index against the band edges as they were one cycle earlier, because the bin emitted at a frame boundary still belongs to the old layout.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    BIN_NULL  = 2'd0,
    BIN_PILOT = 2'd1,
    BIN_DATA  = 2'd2
  } bin_kind_e;
endpackage

// File: rtl/mapper_cfg_latch.sv
module mapper_cfg_latch #(
  parameter int CW = 9,
  parameter int SW = 10,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cfg_nfft,
  input  logic [CW-1:0] cfg_nused,
  input  logic [SW-1:0] cfg_nsym,
  input  logic [GW-1:0] cfg_guard,
  output logic [CW-1:0] nfft_q,
  output logic [SW-1:0] nsym_q,
  output logic [CW-1:0] lo_q,
  output logic [CW-1:0] hi_q,
  output logic [GW-1:0] guard_q
);
  logic [CW-1:0] lo_next;

  // low edge of the used band: half of the null carriers
  assign lo_next = (cfg_nfft - cfg_nused) >> 1;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      nfft_q  <= cfg_nfft;
      nsym_q  <= cfg_nsym;
      lo_q    <= lo_next;
      hi_q    <= lo_next + cfg_nused;
      guard_q <= cfg_guard;
    end
  end
endmodule

// File: rtl/mapper_walker.sv
module mapper_walker #(
  parameter int CW = 9,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] nfft,
  input  logic [SW-1:0] nsym,
  output logic [CW-1:0] bin_q,
  output logic [SW-1:0] sym_q,
  output logic          frame_end
);
  logic last_bin;

  assign last_bin  = (bin_q == nfft - CW'(1));
  assign frame_end = last_bin && (sym_q == nsym);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      sym_q <= '0;
    end else if (step) begin
      if (last_bin) begin
        bin_q <= '0;
        sym_q <= (sym_q == nsym) ? '0 : sym_q + SW'(1);
      end else begin
        bin_q <= bin_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mapper_classify.sv
module mapper_classify
  import mapper_pkg::*;
#(
  parameter int CW = 9,
  parameter int SW = 10
) (
  input  logic [CW-1:0] bin,
  input  logic [SW-1:0] sym,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output bin_kind_e     kind
);
  logic in_band;

  assign in_band = (bin >= lo) && (bin < hi);

  always_comb begin
    if (!in_band)         kind = BIN_NULL;
    else if (sym == '0)   kind = BIN_PILOT;
    else                  kind = BIN_DATA;
  end
endmodule

// File: rtl/subcarrier_mapper.sv
module subcarrier_mapper
  import mapper_pkg::*;
#(
  parameter int DW       = 12,
  parameter int NFFT_MAX = 256,
  parameter int NSYM_MAX = 1023,
  parameter int GW       = 8,
  parameter int PILOT_RE = 1448
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [$clog2(NFFT_MAX+1)-1:0]    cfg_nfft,
  input  logic [$clog2(NFFT_MAX+1)-1:0]    cfg_nused,
  input  logic [$clog2(NSYM_MAX+1)-1:0]    cfg_nsym,
  input  logic [GW-1:0]                    cfg_guard,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [DW-1:0]                    in_i,
  input  logic [DW-1:0]                    in_q,
  output logic                             o_valid,
  output logic [DW-1:0]                    o_i,
  output logic [DW-1:0]                    o_q,
  output logic [$clog2(NFFT_MAX+1)-1:0]    o_bin,
  output logic                             o_sym_start,
  output logic                             o_frame_start,
  output logic [GW-1:0]                    o_guard
);
  localparam int CW = $clog2(NFFT_MAX + 1);
  localparam int SW = $clog2(NSYM_MAX + 1);
  localparam logic [DW-1:0] PILOT_WORD = DW'(PILOT_RE);

  logic [CW-1:0] nfft_sh, lo_sh, hi_sh, bin_c;
  logic [SW-1:0] nsym_sh, sym_c;
  logic [GW-1:0] guard_sh;
  logic          frame_end, step, load;
  bin_kind_e     kind;

  assign step     = !rst && ((kind != BIN_DATA) || in_valid);
  assign load     = step && frame_end;
  assign in_ready = !rst && (kind == BIN_DATA);

  mapper_cfg_latch #(.CW(CW), .SW(SW), .GW(GW)) cfg_i (
    .clk(clk), .rst(rst), .load(load),
    .cfg_nfft(cfg_nfft), .cfg_nused(cfg_nused),
    .cfg_nsym(cfg_nsym), .cfg_guard(cfg_guard),
    .nfft_q(nfft_sh), .nsym_q(nsym_sh),
    .lo_q(lo_sh), .hi_q(hi_sh), .guard_q(guard_sh)
  );

  mapper_walker #(.CW(CW), .SW(SW)) walk_i (
    .clk(clk), .rst(rst), .step(step),
    .nfft(nfft_sh), .nsym(nsym_sh),
    .bin_q(bin_c), .sym_q(sym_c), .frame_end(frame_end)
  );

  mapper_classify #(.CW(CW), .SW(SW)) cls_i (
    .bin(bin_c), .sym(sym_c), .lo(lo_sh), .hi(hi_sh), .kind(kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid       <= 1'b0;
      o_i           <= '0;
      o_q           <= '0;
      o_bin         <= '0;
      o_sym_start   <= 1'b0;
      o_frame_start <= 1'b0;
      o_guard       <= '0;
    end else begin
      o_valid       <= step;
      o_guard       <= guard_sh;
      o_sym_start   <= step && (bin_c == '0);
      o_frame_start <= step && (bin_c == '0) && (sym_c == '0);
      if (step) o_bin <= bin_c;
      if (step && kind == BIN_DATA) begin
        o_i <= in_i;
        o_q <= in_q;
      end else if (step && kind == BIN_PILOT) begin
        o_i <= PILOT_WORD;
        o_q <= '0;
      end else begin
        o_i <= '0;
        o_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
  parameter int CW = 9,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_i,
  input logic [DW-1:0] in_q,
  input logic          o_valid,
  input logic [DW-1:0] o_i,
  input logic [DW-1:0] o_q,
  input logic [CW-1:0] o_bin,
  input logic          o_sym_start,
  input logic          o_frame_start,
  input logic [CW-1:0] lo,
  input logic [CW-1:0] hi
);
  // band edges as seen when the bin now on the outputs was chosen
  logic [CW-1:0] lo_d, hi_d;
  always_ff @(posedge clk) begin
    lo_d <= lo;
    hi_d <= hi;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!o_valid && !o_sym_start && !o_frame_start));

  p_ready_low_r1: assert property (@(posedge clk)
    rst |-> !in_ready);

  p_frame_on_bin0_r2: assert property (@(posedge clk) disable iff (rst)
    o_frame_start |-> (o_sym_start && o_bin == '0));

  p_null_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !$past(rst) && (o_bin < lo_d || o_bin >= hi_d)) |-> (o_i == '0 && o_q == '0));

  p_chip_passes_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (o_valid && o_i == $past(in_i) && o_q == $past(in_q)));

  p_stall_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !o_valid);

  p_sym_on_bin0_r8: assert property (@(posedge clk) disable iff (rst)
    o_sym_start |-> (o_valid && o_bin == '0));
endmodule

bind subcarrier_mapper mapper_chk #(.CW(CW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_i(in_i), .in_q(in_q), .o_valid(o_valid), .o_i(o_i), .o_q(o_q),
  .o_bin(o_bin), .o_sym_start(o_sym_start), .o_frame_start(o_frame_start),
  .lo(lo_sh), .hi(hi_sh)
);

// File: tb/subcarrier_mapper_tb_top.sv
`timescale 1ns/1ps
module subcarrier_mapper_tb_top;
  localparam int DW = 12;
  localparam int CW = 9;
  localparam int SW = 10;
  localparam int GW = 8;
  localparam int PILOT = 1448;

  logic          clk = 1'b0;
  logic          rst;
  logic [CW-1:0] cfg_nfft, cfg_nused;
  logic [SW-1:0] cfg_nsym;
  logic [GW-1:0] cfg_guard;
  logic          in_valid, in_ready;
  logic [DW-1:0] in_i, in_q;
  logic          o_valid, o_sym_start, o_frame_start;
  logic [DW-1:0] o_i, o_q;
  logic [CW-1:0] o_bin;
  logic [GW-1:0] o_guard;

  always #2.5 clk = ~clk;

  subcarrier_mapper dut_i (
    .clk(clk), .rst(rst), .cfg_nfft(cfg_nfft), .cfg_nused(cfg_nused),
    .cfg_nsym(cfg_nsym), .cfg_guard(cfg_guard), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .o_valid(o_valid),
    .o_i(o_i), .o_q(o_q), .o_bin(o_bin), .o_sym_start(o_sym_start),
    .o_frame_start(o_frame_start), .o_guard(o_guard)
  );

  int nvec = 0, nfail = 0, cyc = 0, k = 0, mode = 0;
  int mbin, msym, mnfft, mnsym, mlo, mhi, mguard;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int chip_i(int n); return (n * 37 + 5) & 12'hFFF; endfunction
  function automatic int chip_q(int n); return (n * 11 + 3) & 12'hFFF; endfunction

  task automatic load_model();
    mnfft  = int'(cfg_nfft);
    mnsym  = int'(cfg_nsym);
    mlo    = (int'(cfg_nfft) - int'(cfg_nused)) / 2;
    mhi    = mlo + int'(cfg_nused);
    mguard = int'(cfg_guard);
  endtask

  task automatic set_cfg(int nf, int nu, int ns, int g);
    cfg_nfft = CW'(nf); cfg_nused = CW'(nu); cfg_nsym = SW'(ns); cfg_guard = GW'(g);
  endtask

  // one clock: called at a falling edge, returns at the next one
  task automatic cycle();
    bit data, vld, step, ev, esym, efs;
    int ebin, ei, eq, kind;
    string binreq;
    data = (msym != 0) && (mbin >= mlo) && (mbin < mhi);
    kind = (mbin < mlo || mbin >= mhi) ? 0 : (msym == 0 ? 1 : 2);
    case (mode)
      0: vld = 1'b1;
      1: vld = (cyc % 3) != 0;
      default: vld = (cyc % 4) == 0;
    endcase
    in_valid = vld;
    in_i = DW'(chip_i(k));
    in_q = DW'(chip_q(k));
    chk("R6 in_ready", int'(in_ready), int'(data));
    step = !data || vld;
    ev = step; ebin = mbin; esym = (mbin == 0); efs = (mbin == 0) && (msym == 0);
    ei = (kind == 2) ? chip_i(k) : (kind == 1 ? PILOT : 0);
    eq = (kind == 2) ? chip_q(k) : 0;
    binreq = (int'(cfg_nfft) != mnfft || int'(cfg_nsym) != mnsym ||
              int'(cfg_guard) != mguard) ? "R9 bin order" : "R2 bin order";
    if (step) begin
      if (data) k++;
      if (mbin == mnfft - 1) begin
        mbin = 0;
        if (msym == mnsym) begin msym = 0; load_model(); end
        else msym++;
      end else mbin++;
    end
    @(negedge clk);
    cyc++;
    chk("R7 o_valid", int'(o_valid), int'(ev));
    if (ev) begin
      chk(binreq, int'(o_bin), ebin);
      if (kind == 0) begin
        chk("R3 null I", int'(o_i), 0);
        chk("R3 null Q", int'(o_q), 0);
      end else if (kind == 1) begin
        chk("R4 pilot I", int'(o_i), ei);
        chk("R4 pilot Q", int'(o_q), 0);
      end else begin
        chk("R5 data I", int'(o_i), ei);
        chk("R5 data Q", int'(o_q), eq);
      end
      chk("R8 sym_start", int'(o_sym_start), int'(esym));
      chk("R2 frame_start", int'(o_frame_start), int'(efs));
      if (efs) chk("R10 guard", int'(o_guard), mguard);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0;
    set_cfg(16, 12, 3, 4);
    repeat (3) begin
      @(negedge clk);
      chk("R1 o_valid", int'(o_valid), 0);
      chk("R1 in_ready", int'(in_ready), 0);
      chk("R1 frame_start", int'(o_frame_start), 0);
    end
    rst = 1'b0;
    mbin = 0; msym = 0; load_model();
    mode = 0; repeat (200) cycle();
    mode = 1; repeat (30) cycle();
    set_cfg(8, 8, 1, 2);                 // mid-frame change, held off to next frame
    repeat (300) cycle();
    set_cfg(64, 48, 2, 16);
    mode = 2; repeat (1300) cycle();
    set_cfg(256, 192, 1, 40);
    mode = 0; repeat (1100) cycle();
    set_cfg(8, 6, 5, 9);
    mode = 1; repeat (200) cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule